// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block walks an SDRAM controller through its start-up ritual once software or a reset manager pulses `start`. It speaks to the controller through a small register-write port (`reg_wr`, `reg_sel`, `reg_wdata`) and a separate one-cycle command strobe. The strobe stands for the dummy memory access that makes the controller put the command code it currently holds onto the SDRAM pins. Only the order and the count of register writes and strobes are modelled. Pin timing, mode-register contents and the refresh timer are left to the controller.

The run first makes the controller safe by clearing write buffering and ECC and loading the slowest timing value. It then sends a NOP and waits a fixed number of clock cycles before it precharges every bank. Next come a short refresh burst, a mode-register load and a longer refresh burst, after which the controller returns to normal operation. At the end the timing byte is rewritten with the CAS latency chosen at start, the mode register is loaded a second time, and refresh is switched on. `busy` covers the whole run. `done` then stays high until the next `start`.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `busy`, `done`, `reg_wr` and `cmd_stb` all at 0.
- R2: The first three writes of a run are, in this order: select 0 (write-buffer control) with 0x00, select 1 (ECC control) with 0x00, and select 2 (timing) with `SLOW_TIMING` (default 0x1E). All three come before any write to select 3 (command).
- R3: Command codes written to select 3 are 0x01 NOP, 0x02 precharge all banks, 0x04 auto refresh, 0x03 load mode register, 0x00 normal mode and 0x18 normal mode with refresh enabled.
- R4: The full run is exactly: the three writes of R2; NOP; wait; precharge; refresh; load mode; refresh; normal; final timing write; load mode; 0x18. That makes 26 port events in total.
- R5: Each NOP, precharge and load-mode write is followed in the next cycle by exactly one strobe. Each refresh write is followed by `PRE_REFRESH` (default 2) strobes the first time and `POST_REFRESH` (default 8) strobes the second time, with one strobe per cycle. The normal-mode, 0x18 and register writes get no strobe.
- R6: Between the NOP strobe and the precharge write there are exactly `DLY_CYCLES` cycles with no write and no strobe.
- R7: The final timing write (select 2) is `SLOW_TIMING` with bit 4 cleared when `cas_mode`=1 (latency 2), with bit 4 set when `cas_mode`=2 (latency 3), and unchanged for 0 or 3. `cas_mode` is captured in the cycle `start` is accepted, so later changes have no effect on that run.
- R8: A `start` pulse while `busy` is high is ignored: the run's events and its length are unchanged.
- R9: `busy` rises in the cycle after `start` is accepted and stays high through the 0x18 write. `done` rises in the following cycle and stays high, with no port activity, until the next `start`. The next `start` clears `done` and begins a new run.
- R10: `reg_wr` and `cmd_stb` are never high in the same cycle, and each port event lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run; accepted only when not busy |
| cas_mode | input | 2 | 0/3 keep timing, 1 latency 2, 2 latency 3; captured at start |
| reg_wr | output | 1 | Controller register write enable |
| reg_sel | output | 2 | Register select: 0 write buffer, 1 ECC, 2 timing, 3 command |
| reg_wdata | output | 8 | Register write data |
| cmd_stb | output | 1 | Dummy-access strobe that makes the held command take effect |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; held until next start |

## Verification
Each run is logged cycle by cycle, capturing every write, every strobe and the cycle it occurred in, and the log is compared with a list the bench builds from the requirements. Runs differ in the CAS choice, and one run changes `cas_mode` partway through, so a design that samples it late produces the wrong final timing byte. Another run pulses `start` during the wait, which exposes a sequencer that restarts. A run that starts straight from `done` checks the hand-off between runs. Measuring the gap between the NOP strobe and the precharge, and the cycle in which `done` rises, exposes any off-by-one in the wait counter or in the refresh burst counters.

// File: rtl/sdram_pwrup_pkg.sv
// Shared types and constants for the SDRAM power-up sequencer.
// Assumes a controller that latches a command code and acts on it
// when a separate dummy-access strobe follows.
package sdram_pwrup_pkg;

    typedef enum logic [1:0] {
        K_WRITE  = 2'd0,
        K_STROBE = 2'd1,
        K_WAIT   = 2'd2
    } step_kind_e;

    localparam logic [1:0] SEL_WBUF   = 2'd0;
    localparam logic [1:0] SEL_ECC    = 2'd1;
    localparam logic [1:0] SEL_TIMING = 2'd2;
    localparam logic [1:0] SEL_CMD    = 2'd3;

    localparam logic [7:0] OP_NORMAL    = 8'h00;
    localparam logic [7:0] OP_NOP       = 8'h01;
    localparam logic [7:0] OP_PRECHARGE = 8'h02;
    localparam logic [7:0] OP_LOAD_MODE = 8'h03;
    localparam logic [7:0] OP_REFRESH   = 8'h04;
    localparam logic [7:0] OP_RUN       = 8'h18;

    localparam logic [1:0] CAS_TWO   = 2'd1;
    localparam logic [1:0] CAS_THREE = 2'd2;

    localparam int STEP_COUNT = 19;
    localparam int STEP_W     = $clog2(STEP_COUNT);

endpackage

// File: rtl/pwrup_step_rom.sv
// Step decoder: maps the step index to what the step does on the
// controller port (write, strobe burst or wait), its select, data and
// strobe count. Pure combinational; assumes cas_mode is already held.
module pwrup_step_rom
    import sdram_pwrup_pkg::*;
#(
    parameter logic [7:0] SLOW_TIMING  = 8'h1E,
    parameter int         PRE_REFRESH  = 2,
    parameter int         POST_REFRESH = 8,
    parameter int         REP_W        = 4
) (
    input  logic [STEP_W-1:0] step,
    input  logic [1:0]        cas_mode,
    output step_kind_e        kind,
    output logic [1:0]        sel,
    output logic [7:0]        data,
    output logic [REP_W-1:0]  reps
);

    localparam logic [REP_W-1:0] ONE_REP  = REP_W'(1);
    localparam logic [REP_W-1:0] PRE_REP  = REP_W'(PRE_REFRESH);
    localparam logic [REP_W-1:0] POST_REP = REP_W'(POST_REFRESH);

    logic [7:0] final_timing;

    // Final timing byte: latency bit 4 adjusted from the held CAS choice.
    always_comb begin
        case (cas_mode)
            CAS_TWO:   final_timing = SLOW_TIMING & 8'hEF;
            CAS_THREE: final_timing = SLOW_TIMING | 8'h10;
            default:   final_timing = SLOW_TIMING;
        endcase
    end

    // Step table: ordering of the whole power-up run.
    always_comb begin
        kind = K_WRITE;
        sel  = SEL_CMD;
        data = OP_NORMAL;
        reps = ONE_REP;
        case (step)
            5'd0:  begin sel = SEL_WBUF;   data = 8'h00;        end
            5'd1:  begin sel = SEL_ECC;    data = 8'h00;        end
            5'd2:  begin sel = SEL_TIMING; data = SLOW_TIMING;  end
            5'd3:  data = OP_NOP;
            5'd4:  kind = K_STROBE;
            5'd5:  kind = K_WAIT;
            5'd6:  data = OP_PRECHARGE;
            5'd7:  kind = K_STROBE;
            5'd8:  data = OP_REFRESH;
            5'd9:  begin kind = K_STROBE; reps = PRE_REP;  end
            5'd10: data = OP_LOAD_MODE;
            5'd11: kind = K_STROBE;
            5'd12: data = OP_REFRESH;
            5'd13: begin kind = K_STROBE; reps = POST_REP; end
            5'd14: data = OP_NORMAL;
            5'd15: begin sel = SEL_TIMING; data = final_timing; end
            5'd16: data = OP_LOAD_MODE;
            5'd17: kind = K_STROBE;
            5'd18: data = OP_RUN;
            default: kind = K_WAIT;
        endcase
    end

endmodule

// File: rtl/pwrup_delay.sv
// Settle-delay timer: while active, counts DLY_CYCLES cycles and flags
// the last one. Reloads whenever inactive. Assumes DLY_CYCLES >= 1.
module pwrup_delay #(
    parameter int DLY_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic expired
);

    localparam int              CNT_W = $clog2(DLY_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(DLY_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Down-counter: reload when idle, decrement while the wait runs.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt_q <= LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = active && (cnt_q == '0);

    // R6
    dly_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD);

    // R6
    dly_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> cnt_q == LOAD);

endmodule

// File: rtl/pwrup_burst.sv
// Strobe burst counter: while active, counts strobes and flags the one
// that completes the requested repeat count. Assumes reps >= 1.
module pwrup_burst #(
    parameter int REP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [REP_W-1:0] reps,
    output logic             last
);

    logic [REP_W-1:0] cnt_q;

    assign last = active && ((cnt_q + REP_W'(1)) == reps);

    // Up-counter of strobes already issued in the current burst.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + REP_W'(1);
        end
    end

    // R5
    burst_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> cnt_q < reps);

endmodule

// File: rtl/sdram_pwrup_seq.sv
// SDRAM power-up command sequencer (top). After start it steps through
// the fixed register-write / strobe / wait table, one port event per
// cycle, then holds done until the next start. Assumes the controller
// accepts one register write or one strobe per cycle.
module sdram_pwrup_seq
    import sdram_pwrup_pkg::*;
#(
    parameter int         DLY_CYCLES   = 100,
    parameter int         PRE_REFRESH  = 2,
    parameter int         POST_REFRESH = 8,
    parameter logic [7:0] SLOW_TIMING  = 8'h1E
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] cas_mode,
    output logic       reg_wr,
    output logic [1:0] reg_sel,
    output logic [7:0] reg_wdata,
    output logic       cmd_stb,
    output logic       busy,
    output logic       done
);

    localparam int REP_MAX = (PRE_REFRESH > POST_REFRESH) ? PRE_REFRESH : POST_REFRESH;
    localparam int REP_W   = $clog2(REP_MAX + 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEP_COUNT - 1);

    logic [STEP_W-1:0] step_q;
    logic              busy_q;
    logic              done_q;
    logic [1:0]        cas_q;

    step_kind_e        kind;
    logic [1:0]        rom_sel;
    logic [7:0]        rom_data;
    logic [REP_W-1:0]  rom_reps;
    logic              dly_expired;
    logic              burst_last;
    logic              advance;
    logic              at_end;

    pwrup_step_rom #(
        .SLOW_TIMING (SLOW_TIMING),
        .PRE_REFRESH (PRE_REFRESH),
        .POST_REFRESH(POST_REFRESH),
        .REP_W       (REP_W)
    ) rom_i (
        .step    (step_q),
        .cas_mode(cas_q),
        .kind    (kind),
        .sel     (rom_sel),
        .data    (rom_data),
        .reps    (rom_reps)
    );

    pwrup_delay #(
        .DLY_CYCLES(DLY_CYCLES)
    ) delay_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (busy_q && kind == K_WAIT),
        .expired(dly_expired)
    );

    pwrup_burst #(
        .REP_W(REP_W)
    ) burst_i (
        .clk   (clk),
        .rst_n (rst_n),
        .active(busy_q && kind == K_STROBE),
        .reps  (rom_reps),
        .last  (burst_last)
    );

    // Step completion: writes take one cycle, bursts and waits their count.
    always_comb begin
        case (kind)
            K_WRITE:  advance = busy_q;
            K_STROBE: advance = busy_q && burst_last;
            K_WAIT:   advance = busy_q && dly_expired;
            default:  advance = 1'b0;
        endcase
    end

    assign at_end = (step_q == LAST_STEP);

    // Run control: accept start when idle, walk the table, raise done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cas_q  <= 2'd0;
        end else if (!busy_q && start) begin
            step_q <= '0;
            busy_q <= 1'b1;
            done_q <= 1'b0;
            cas_q  <= cas_mode;
        end else if (advance) begin
            if (at_end) begin
                step_q <= '0;
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end else begin
                step_q <= step_q + STEP_W'(1);
            end
        end
    end

    // Port drive: decoded step, gated by busy so idle cycles stay quiet.
    assign reg_wr    = busy_q && (kind == K_WRITE);
    assign cmd_stb   = busy_q && (kind == K_STROBE);
    assign reg_sel   = reg_wr ? rom_sel  : 2'd0;
    assign reg_wdata = reg_wr ? rom_data : 8'h00;
    assign busy      = busy_q;
    assign done      = done_q;

    localparam int WAIT_W = $clog2(DLY_CYCLES + 1);
    logic [WAIT_W-1:0] wait_len_q;

    // Checker counter: cycles spent so far in the current wait step.
    always_ff @(posedge clk) begin
        if (!rst_n || !(busy_q && kind == K_WAIT)) begin
            wait_len_q <= '0;
        end else if (wait_len_q != WAIT_W'(DLY_CYCLES)) begin
            wait_len_q <= wait_len_q + WAIT_W'(1);
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> !busy && !done && !reg_wr && !cmd_stb);

    // R5
    strobe_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> $past(cmd_stb) || $past(reg_wr && reg_sel == SEL_CMD));

    // R6
    wait_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && kind == K_WAIT && dly_expired) |-> wait_len_q == WAIT_W'(DLY_CYCLES - 1));

    // R7
    final_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_TIMING && $past(reg_wr && reg_sel == SEL_CMD && reg_wdata == OP_NORMAL))
        |-> (cas_q != CAS_TWO || !reg_wdata[4]) && (cas_q != CAS_THREE || reg_wdata[4]));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(advance && at_end)) |=> busy);

    // R9
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !reg_wr && !cmd_stb);

    // R9
    done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(reg_wr && reg_sel == SEL_CMD && reg_wdata == OP_RUN));

    // R10
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && cmd_stb));

endmodule

// File: tb/sdram_pwrup_seq_tb.sv
module sdram_pwrup_seq_tb_top;

    localparam int DLY = 40;
    localparam int NEV = 26;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] cas_mode = 2'd0;
    logic       reg_wr;
    logic [1:0] reg_sel;
    logic [7:0] reg_wdata;
    logic       cmd_stb;
    logic       busy;
    logic       done;

    int tests = 0;
    int fails = 0;

    logic [11:0] exp_ev [64];
    int          n_exp;
    logic [11:0] got_ev [64];
    int          got_cyc [64];
    int          n_got;

    always #10 clk = ~clk;

    sdram_pwrup_seq #(.DLY_CYCLES(DLY)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cas_mode(cas_mode),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .cmd_stb(cmd_stb), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic push_w(input logic [1:0] s, input logic [7:0] d);
        exp_ev[n_exp] = {1'b1, 1'b0, s, d};
        n_exp++;
    endtask

    task automatic push_s(input int n);
        for (int i = 0; i < n; i++) begin
            exp_ev[n_exp] = {1'b0, 1'b1, 2'd0, 8'h00};
            n_exp++;
        end
    endtask

    // Expected event list from R2..R5 and R7.
    task automatic build_exp(input logic [7:0] fin_tim);
        n_exp = 0;
        push_w(2'd0, 8'h00); push_w(2'd1, 8'h00); push_w(2'd2, 8'h1E);
        push_w(2'd3, 8'h01); push_s(1);
        push_w(2'd3, 8'h02); push_s(1);
        push_w(2'd3, 8'h04); push_s(2);
        push_w(2'd3, 8'h03); push_s(1);
        push_w(2'd3, 8'h04); push_s(8);
        push_w(2'd3, 8'h00);
        push_w(2'd2, fin_tim);
        push_w(2'd3, 8'h03); push_s(1);
        push_w(2'd3, 8'h18);
    endtask

    // One full run; optional mid-run CAS change and start-while-busy pulse.
    task automatic run_seq(input logic [1:0] cas, input logic [1:0] cas_late,
                           input bit poke_start, input logic [7:0] fin_tim,
                           input string tag);
        int cyc = 0;
        int done_cyc = 0;
        int busy_bad = 0;
        int mism = 0;
        build_exp(fin_tim);
        n_got = 0;
        @(negedge clk);
        cas_mode = cas;
        start = 1'b1;
        while (done_cyc == 0 && cyc < 2000) begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
            if (cyc == 1) chk(busy && !done, {tag, " R9 busy set, done cleared"}, {busy, done}, 2'b10);
            if (cyc == 3) cas_mode = cas_late;
            if (poke_start && cyc == 10) start = 1'b1;
            if (reg_wr && cmd_stb) busy_bad++;
            if (reg_wr || cmd_stb) begin
                if (!busy) busy_bad++;
                if (n_got < 64) begin
                    got_ev[n_got]  = {reg_wr, cmd_stb, reg_sel, reg_wdata};
                    got_cyc[n_got] = cyc;
                end
                n_got++;
            end
            if (done) done_cyc = cyc;
        end
        chk(n_got == NEV, {tag, " R4 event count"}, n_got, NEV);
        for (int i = 0; i < NEV && i < n_got; i++) begin
            if (got_ev[i] != exp_ev[i]) mism++;
            if (i < 3)
                chk(got_ev[i] == exp_ev[i], {tag, " R2 setup write"}, got_ev[i], exp_ev[i]);
        end
        chk(mism == 0, {tag, " R3 R4 R5 command and strobe list"}, mism, 0);
        if (n_got >= 23)
            chk(got_ev[22] == {4'b1010, fin_tim}, {tag, " R7 final timing"}, got_ev[22], {4'b1010, fin_tim});
        if (n_got >= 6)
            chk(got_cyc[5] - got_cyc[4] == DLY + 1, {tag, " R6 settle gap"}, got_cyc[5] - got_cyc[4], DLY + 1);
        chk(done_cyc == NEV + DLY + 1, {tag, " R9 R8 done cycle"}, done_cyc, NEV + DLY + 1);
        chk(busy_bad == 0, {tag, " R9 R10 busy and exclusive events"}, busy_bad, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(done && !busy && !reg_wr && !cmd_stb, {tag, " R9 done held, port quiet"},
                {done, busy, reg_wr, cmd_stb}, 4'b1000);
        end
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk({busy, done, reg_wr, cmd_stb} == 4'b0, "R1 reset state", {busy, done, reg_wr, cmd_stb}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({busy, done, reg_wr, cmd_stb} == 4'b0, "R1 idle after reset", {busy, done, reg_wr, cmd_stb}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        test_reset();
        run_seq(2'd0, 2'd0, 1'b0, 8'h1E, "keep");          // R7 default timing
        run_seq(2'd1, 2'd2, 1'b0, 8'h0E, "cl2_latched");   // R7 capture at start
        run_seq(2'd2, 2'd1, 1'b1, 8'h1E, "cl3_poke");      // R8 start ignored while busy
        run_seq(2'd3, 2'd3, 1'b0, 8'h1E, "mode3");         // R9 restart from done
        test_reset();                                      // R1 reset after done
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule